// File: doc/BRIEF.md
# Ring Node Forwarding Arbiter

This block sits in each node of a one-way ring network and owns the node's transmit path. Every packet that arrives from the upstream neighbour is either passed on to the downstream neighbour or taken off the ring. A packet is taken off when it has travelled all the way round and come back to the node that sent it, or when the link decoder has flagged it as corrupt. Packets produced locally are slotted into the gaps between packets that are passing through. The block never cuts into the middle of a packet.

A packet is a run of words. The first word carries the start flag and the last word carries the end flag. The first word is also the header, and it holds the source and destination node IDs. The arbiter decides which source owns the output at each packet boundary and holds that choice until the end word has been transferred. While it forwards a packet addressed to this node, it also presents a copy of each word on a delivery output. When a corrupt packet is removed, a sticky status bit is set. That bit can raise an interrupt line if the interrupt is enabled.

Top module: `ring_fwd_arb`

## Requirements
- R1: A received packet is sent downstream word for word, with its start and end flags, when its source ID differs from `node_id` and its error flag is low. The header sits in the start word: source ID in data bits [ID_W-1:0], destination ID in bits [2*ID_W-1:ID_W].
- R2: A received packet whose source ID equals `node_id` is accepted from upstream and never appears on the downstream output.
- R3: A received packet with `rx_err` high on its start word is accepted and never appears on the downstream output.
- R4: Local packets are started only at a packet boundary. Once a packet has begun on the downstream output, no other packet's words appear there until its end word has been transferred.
- R5: When an upstream packet and a local packet are both offered at a boundary, the upstream packet goes first and `loc_ready` stays low.
- R6: While `tx_valid` is high and `tx_ready` is low, the downstream word and its source are held unchanged, even if another packet arrives.
- R7: Every word of a forwarded packet whose destination ID equals `node_id` is copied to the delivery output in the cycle it is transferred downstream. No other packet is delivered.
- R8: `err_pend` becomes 1 in the cycle after a packet with `rx_err` set has its start word removed. It stays 1 until `err_clr` is pulsed. A new error in the same cycle as the clear keeps it set.
- R9: `err_irq` is high exactly when `err_pend` and `irq_en` are both high.
- R10: After reset, `tx_valid`, `rx_ready`, `loc_ready`, `dlv_valid`, `err_pend` and `err_irq` are all 0 while no input is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| node_id | input | ID_W | Static ID of this node |
| irq_en | input | 1 | Error interrupt enable |
| err_clr | input | 1 | Write-one-to-clear pulse for the error bit |
| rx_valid | input | 1 | Upstream word valid |
| rx_ready | output | 1 | Upstream word accepted |
| rx_data | input | DATA_W | Upstream word |
| rx_sop | input | 1 | Upstream start-of-packet |
| rx_eop | input | 1 | Upstream end-of-packet |
| rx_err | input | 1 | Decoder error flag, qualified with the start word |
| loc_valid | input | 1 | Local word valid |
| loc_ready | output | 1 | Local word accepted |
| loc_data | input | DATA_W | Local word |
| loc_sop | input | 1 | Local start-of-packet |
| loc_eop | input | 1 | Local end-of-packet |
| tx_valid | output | 1 | Downstream word valid |
| tx_ready | input | 1 | Downstream ready |
| tx_data | output | DATA_W | Downstream word |
| tx_sop | output | 1 | Downstream start-of-packet |
| tx_eop | output | 1 | Downstream end-of-packet |
| dlv_valid | output | 1 | Delivery copy valid |
| dlv_data | output | DATA_W | Delivery copy word |
| dlv_sop | output | 1 | Delivery start-of-packet |
| dlv_eop | output | 1 | Delivery end-of-packet |
| err_pend | output | 1 | Sticky error status |
| err_irq | output | 1 | Gated error interrupt |

## Verification
The bench builds the block with ID_W=4 and DATA_W=16, and ties the node ID to 5. Four-bit IDs make both ends of the ID range reachable: source 0 with destination 15, and source 15 with destination 0. A sixteen-bit word leaves room for payload values that are easy to tell apart from the header. Two-word packets from upstream and one-word to three-word local packets are enough to show how the lock is held across a packet, how long local packets are deferred by an arriving upstream packet, and how the output behaves under backpressure at a boundary.

// File: rtl/ring_arb_pkg.sv
package ring_arb_pkg;
  typedef enum logic [1:0] {
    P_IDLE = 2'd0,
    P_FWD  = 2'd1,
    P_DROP = 2'd2,
    P_INS  = 2'd3
  } path_e;
endpackage

// File: rtl/ring_path_sel.sv
module ring_path_sel
  import ring_arb_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   node_id,
  input  logic              rx_valid,
  input  logic [2*ID_W-1:0] rx_hdr,
  input  logic              rx_err,
  input  logic              rx_eop,
  input  logic              loc_valid,
  input  logic              loc_eop,
  input  logic              tx_ready,
  output path_e             cur_path,
  output logic              at_boundary,
  output logic              to_me,
  output logic              err_evt
);
  localparam int HDR_W = 2 * ID_W;

  function automatic logic [ID_W-1:0] hdr_src(input logic [HDR_W-1:0] h);
    return h[ID_W-1:0];
  endfunction

  function automatic logic [ID_W-1:0] hdr_dst(input logic [HDR_W-1:0] h);
    return h[HDR_W-1:ID_W];
  endfunction

  path_e lock_q, decide;
  logic  to_me_q, word_done, last_word;

  assign at_boundary = (lock_q == P_IDLE);

  always_comb begin
    if (rx_valid) begin
      if (rx_err || hdr_src(rx_hdr) == node_id) decide = P_DROP;
      else                                      decide = P_FWD;
    end else if (loc_valid) begin
      decide = P_INS;
    end else begin
      decide = P_IDLE;
    end
  end

  assign cur_path = at_boundary ? decide : lock_q;
  assign to_me    = at_boundary ? (hdr_dst(rx_hdr) == node_id) : to_me_q;
  assign err_evt  = at_boundary && rx_valid && rx_err;

  always_comb begin
    case (cur_path)
      P_FWD:   begin word_done = rx_valid && tx_ready;  last_word = rx_eop;  end
      P_DROP:  begin word_done = rx_valid;              last_word = rx_eop;  end
      P_INS:   begin word_done = loc_valid && tx_ready; last_word = loc_eop; end
      default: begin word_done = 1'b0;                  last_word = 1'b0;    end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= P_IDLE;
      to_me_q <= 1'b0;
    end else begin
      lock_q <= (word_done && last_word) ? P_IDLE : cur_path;
      if (at_boundary) to_me_q <= to_me;
    end
  end
endmodule

// File: rtl/ring_err_flag.sv
module ring_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_pulse,
  input  logic irq_en,
  output logic pend,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pend <= 1'b0;
    else if (set_evt)   pend <= 1'b1;
    else if (clr_pulse) pend <= 1'b0;
  end

  assign irq = pend && irq_en;
endmodule

// File: rtl/ring_fwd_arb.sv
module ring_fwd_arb
  import ring_arb_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   node_id,
  input  logic              irq_en,
  input  logic              err_clr,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_sop,
  input  logic              rx_eop,
  input  logic              rx_err,
  input  logic              loc_valid,
  output logic              loc_ready,
  input  logic [DATA_W-1:0] loc_data,
  input  logic              loc_sop,
  input  logic              loc_eop,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_sop,
  output logic              tx_eop,
  output logic              dlv_valid,
  output logic [DATA_W-1:0] dlv_data,
  output logic              dlv_sop,
  output logic              dlv_eop,
  output logic              err_pend,
  output logic              err_irq
);
  localparam int HDR_W = 2 * ID_W;

  path_e cur_path;
  logic  at_boundary, to_me, err_evt, fwd_xfer;

  ring_path_sel #(.ID_W(ID_W)) i_sel (
    .clk(clk), .rst_n(rst_n), .node_id(node_id),
    .rx_valid(rx_valid), .rx_hdr(rx_data[HDR_W-1:0]), .rx_err(rx_err),
    .rx_eop(rx_eop), .loc_valid(loc_valid), .loc_eop(loc_eop),
    .tx_ready(tx_ready), .cur_path(cur_path), .at_boundary(at_boundary),
    .to_me(to_me), .err_evt(err_evt)
  );

  ring_err_flag i_err (
    .clk(clk), .rst_n(rst_n), .set_evt(err_evt), .clr_pulse(err_clr),
    .irq_en(irq_en), .pend(err_pend), .irq(err_irq)
  );

  always_comb begin
    rx_ready  = 1'b0;
    loc_ready = 1'b0;
    tx_valid  = 1'b0;
    tx_data   = rx_data;
    tx_sop    = rx_sop;
    tx_eop    = rx_eop;
    case (cur_path)
      P_FWD: begin
        rx_ready = tx_ready;
        tx_valid = rx_valid;
      end
      P_DROP: rx_ready = 1'b1;
      P_INS: begin
        loc_ready = tx_ready;
        tx_valid  = loc_valid;
        tx_data   = loc_data;
        tx_sop    = loc_sop;
        tx_eop    = loc_eop;
      end
      default: ;
    endcase
  end

  assign fwd_xfer  = (cur_path == P_FWD) && rx_valid && tx_ready;
  assign dlv_valid = fwd_xfer && to_me;
  assign dlv_data  = rx_data;
  assign dlv_sop   = rx_sop;
  assign dlv_eop   = rx_eop;
endmodule

// File: rtl/ring_fwd_arb_chk.sv
module ring_fwd_arb_chk
  import ring_arb_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ID_W-1:0]   node_id,
  input logic              irq_en,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_err,
  input logic              loc_ready,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [DATA_W-1:0] tx_data,
  input logic              tx_sop,
  input logic              tx_eop,
  input logic              dlv_valid,
  input logic              err_pend,
  input logic              err_irq,
  input logic              at_boundary,
  input logic              err_evt,
  input path_e             cur_path
);
  // R2, R3: a forwarded header never comes from this node or from an errored packet
  assert_fwd_hdr_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_path == P_FWD && tx_valid && tx_sop && at_boundary)
      |-> (rx_data[ID_W-1:0] != node_id) && !rx_err);

  // R4: after a non-final word goes out, the next output word is not a fresh start
  assert_no_split_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && !tx_eop) |=> !(tx_valid && tx_sop));

  // R5: upstream wins at a boundary
  assert_upstream_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (at_boundary && rx_valid) |-> !loc_ready);

  // R6: a stalled output word is held
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sop)));

  // R7: delivery only alongside a downstream transfer
  assert_dlv_with_fwd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> (tx_valid && tx_ready && cur_path == P_FWD));

  // R8: an error removal sets the sticky bit
  assert_err_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> err_pend);

  // R9: interrupt follows the sticky bit when enabled
  assert_irq_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt && irq_en) |=> (err_irq || !irq_en));
endmodule

bind ring_fwd_arb ring_fwd_arb_chk #(.ID_W(ID_W), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .node_id(node_id), .irq_en(irq_en),
  .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err),
  .loc_ready(loc_ready), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop),
  .dlv_valid(dlv_valid), .err_pend(err_pend), .err_irq(err_irq),
  .at_boundary(at_boundary), .err_evt(err_evt), .cur_path(cur_path)
);

// File: tb/test_ring_fwd_arb.sv
module test_ring_fwd_arb;
  localparam int CLK_PER = 10;
  localparam int ID_W    = 4;
  localparam int DATA_W  = 16;
  localparam logic [ID_W-1:0] MY_ID = 4'd5;
  localparam int NVEC = 8;

  // {src, dst, err, exp tx words, exp dlv words, exp err_pend}
  typedef struct packed {
    logic [3:0] src;
    logic [3:0] dst;
    logic       err;
    logic [1:0] n_tx;
    logic [1:0] n_dlv;
    logic       pend;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{4'd3,  4'd7,  1'b0, 2'd2, 2'd0, 1'b0},
    '{4'd5,  4'd7,  1'b0, 2'd0, 2'd0, 1'b0},
    '{4'd3,  4'd5,  1'b0, 2'd2, 2'd2, 1'b0},
    '{4'd5,  4'd5,  1'b0, 2'd0, 2'd0, 1'b0},
    '{4'd3,  4'd7,  1'b1, 2'd0, 2'd0, 1'b1},
    '{4'd9,  4'd5,  1'b1, 2'd0, 2'd0, 1'b1},
    '{4'd0,  4'd15, 1'b0, 2'd2, 2'd0, 1'b0},
    '{4'd15, 4'd0,  1'b0, 2'd2, 2'd0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic irq_en = 1'b1, err_clr = 1'b0;
  logic rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0, rx_err = 1'b0;
  logic [DATA_W-1:0] rx_data = '0;
  logic loc_valid = 1'b0, loc_sop = 1'b0, loc_eop = 1'b0;
  logic [DATA_W-1:0] loc_data = '0;
  logic tx_ready = 1'b1;
  logic rx_ready, loc_ready, tx_valid, tx_sop, tx_eop;
  logic dlv_valid, dlv_sop, dlv_eop, err_pend, err_irq;
  logic [DATA_W-1:0] tx_data, dlv_data;

  int n_chk = 0, n_bad = 0;
  int cnt_tx, cnt_dlv;
  bit done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  ring_fwd_arb #(.ID_W(ID_W), .DATA_W(DATA_W)) i_ring_fwd_arb (
    .clk(clk), .rst_n(rst_n), .node_id(MY_ID), .irq_en(irq_en), .err_clr(err_clr),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_sop(rx_sop),
    .rx_eop(rx_eop), .rx_err(rx_err), .loc_valid(loc_valid), .loc_ready(loc_ready),
    .loc_data(loc_data), .loc_sop(loc_sop), .loc_eop(loc_eop), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop),
    .dlv_valid(dlv_valid), .dlv_data(dlv_data), .dlv_sop(dlv_sop), .dlv_eop(dlv_eop),
    .err_pend(err_pend), .err_irq(err_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] mk_hdr(input logic [3:0] s, input logic [3:0] d);
    return {8'hA0, d, s};
  endfunction

  // sends a two-word upstream packet, counting downstream and delivery words
  task automatic send_rx(input logic [3:0] s, input logic [3:0] d, input logic e);
    int w = 0;
    cnt_tx = 0; cnt_dlv = 0;
    while (w < 2) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_sop   = (w == 0);
      rx_eop   = (w == 1);
      rx_err   = e;
      rx_data  = (w == 0) ? mk_hdr(s, d) : 16'h1234;
      #(CLK_PER/4);
      if (tx_valid && tx_ready) cnt_tx++;
      if (dlv_valid) cnt_dlv++;
      if (rx_ready) w++;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0; rx_err = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 tx_valid", tx_valid, 0);
    check("R10 rx_ready", rx_ready, 0);
    check("R10 err_pend", err_pend, 0);
    rst_n = 1'b1;
    @(negedge clk); #(CLK_PER/4);
    check("R10 idle loc_ready", loc_ready, 0);
    check("R10 idle dlv_valid", dlv_valid, 0);
    check("R10 idle err_irq", err_irq, 0);

    // table walk: R1 R2 R3 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      send_rx(VECS[i].src, VECS[i].dst, VECS[i].err);
      check($sformatf("R1/R2/R3 vec%0d tx words", i), cnt_tx, VECS[i].n_tx);
      check($sformatf("R7 vec%0d dlv words", i), cnt_dlv, VECS[i].n_dlv);
      #1;
      check($sformatf("R8 vec%0d err_pend", i), err_pend, VECS[i].pend);
      pulse_clr();
      #1;
      check($sformatf("R8 vec%0d cleared", i), err_pend, 0);
    end

    // R5: both offered at a boundary, upstream first
    @(negedge clk);
    rx_valid = 1'b1; rx_sop = 1'b1; rx_eop = 1'b0; rx_data = mk_hdr(4'd3, 4'd7);
    loc_valid = 1'b1; loc_sop = 1'b1; loc_eop = 1'b1; loc_data = 16'hBEEF;
    #(CLK_PER/4);
    check("R5 tx from upstream", tx_data, mk_hdr(4'd3, 4'd7));
    check("R5 loc_ready low", loc_ready, 0);
    @(negedge clk);
    rx_sop = 1'b0; rx_eop = 1'b1; rx_data = 16'h2222;
    #(CLK_PER/4);
    check("R1 second word", tx_data, 16'h2222);
    check("R1 eop passed", tx_eop, 1);
    @(negedge clk);
    rx_valid = 1'b0; rx_eop = 1'b0;
    #(CLK_PER/4);
    check("R5 local after upstream", tx_data, 16'hBEEF);
    check("R5 loc_ready now", loc_ready, 1);
    @(negedge clk);
    loc_valid = 1'b0;

    // R4: upstream arriving mid local packet waits
    @(negedge clk);
    loc_valid = 1'b1; loc_sop = 1'b1; loc_eop = 1'b0; loc_data = 16'h0C00;
    #(CLK_PER/4);
    check("R4 local start", tx_data, 16'h0C00);
    @(negedge clk);
    loc_sop = 1'b0; loc_data = 16'h0C01;
    rx_valid = 1'b1; rx_sop = 1'b1; rx_eop = 1'b0; rx_data = mk_hdr(4'd2, 4'd8);
    #(CLK_PER/4);
    check("R4 local continues", tx_data, 16'h0C01);
    check("R4 upstream held", rx_ready, 0);
    @(negedge clk);
    loc_eop = 1'b1; loc_data = 16'h0C02;
    #(CLK_PER/4);
    check("R4 local end", tx_data, 16'h0C02);
    @(negedge clk);
    loc_valid = 1'b0; loc_eop = 1'b0;
    #(CLK_PER/4);
    check("R4 upstream after local", tx_data, mk_hdr(4'd2, 4'd8));
    check("R4 upstream sop", tx_sop, 1);
    @(negedge clk);
    rx_sop = 1'b0; rx_eop = 1'b1; rx_data = 16'h3333;
    @(negedge clk);
    rx_valid = 1'b0; rx_eop = 1'b0;

    // R6: backpressure holds the chosen source
    @(negedge clk);
    tx_ready = 1'b0;
    loc_valid = 1'b1; loc_sop = 1'b1; loc_eop = 1'b1; loc_data = 16'h0D0D;
    #(CLK_PER/4);
    check("R6 local offered", tx_data, 16'h0D0D);
    @(negedge clk);
    rx_valid = 1'b1; rx_sop = 1'b1; rx_eop = 1'b1; rx_data = mk_hdr(4'd1, 4'd2);
    #(CLK_PER/4);
    check("R6 held under stall", tx_data, 16'h0D0D);
    check("R6 upstream not taken", rx_ready, 0);
    @(negedge clk);
    tx_ready = 1'b1;
    @(negedge clk);
    loc_valid = 1'b0; loc_sop = 1'b0; loc_eop = 1'b0;
    #(CLK_PER/4);
    check("R6 upstream after stall", tx_data, mk_hdr(4'd1, 4'd2));
    @(negedge clk);
    rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;

    // R9: interrupt gating
    irq_en = 1'b0;
    send_rx(4'd3, 4'd7, 1'b1);
    #1;
    check("R9 pend set", err_pend, 1);
    check("R9 irq masked", err_irq, 0);
    @(negedge clk); irq_en = 1'b1; #1;
    check("R9 irq enabled", err_irq, 1);

    // R8: set and clear together, set wins
    @(negedge clk);
    rx_valid = 1'b1; rx_sop = 1'b1; rx_eop = 1'b1; rx_err = 1'b1;
    rx_data = mk_hdr(4'd4, 4'd6); err_clr = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0; rx_err = 1'b0; err_clr = 1'b0;
    #1;
    check("R8 set wins over clear", err_pend, 1);
    pulse_clr(); #1;
    check("R8 clear", err_pend, 0);
    check("R9 irq drops", err_irq, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule